// File: doc/BRIEF.md
# SDRAM Bank Window Decoder

This block holds the configuration words for a small set of memory banks and, from them, works out which bank a 32-bit physical address belongs to. Each bank word packs three things: an 8 MiB-aligned start address in its upper bits, a 3-bit power-of-two size code, and an enable flag in bit 0. A bank takes part in decoding only when its own enable flag and a controller-wide enable input are both high. When the controller-wide enable drops, every bank leaves the map at once.

Configuration words are written through a narrow port that selects one of the bank words by an indirect offset. Every written value is masked before it is stored, and the stored word can be read back at the same offset. The lookup side is purely combinational: the address presented on the lookup port produces a one-hot bank hit, a miss flag and the byte offset of the address inside the selected bank in the same cycle. If two windows overlap, the lower-numbered bank takes the hit.

Top module: `sdram_bank_decoder`

## Requirements
- R1: After reset every bank word reads as zero, no hit bit is set, the miss flag is high and the offset output is zero.
- R2: A write with the write strobe high at offset 0x40 + 4*i stores the data ANDed with 0xFFDEE001 into bank word i on the next rising clock edge; the read port returns that stored word while the offset stays at 0x40 + 4*i.
- R3: A write to any offset other than 0x40, 0x44, 0x48 or 0x4C changes no bank word, and reading such an offset returns zero.
- R4: Bank i spans from base = word[31:23] followed by 23 zero bits, with a size of 4 MiB shifted left by the code in word[19:17]; an address hits it when base <= address < base + size. Bits 22:20 of the word play no part in the base.
- R5: A bank whose size code is 7 never produces a hit.
- R6: A bank whose bit 0 is clear never produces a hit.
- R7: While the global enable input is low, no hit bit is set and the miss flag is high, whatever the bank words hold.
- R8: At most one hit bit is set; when several windows contain the address, the bit of the lowest-numbered bank is set.
- R9: The offset output equals the lookup address minus the base of the bank that wins the hit, and is zero on a miss.
- R10: The miss flag is high exactly when no hit bit is set.
- R11: A window whose end lies at the 4 GiB boundary covers the top address 0xFFFFFFFF; the end of a window is computed without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the bank word port |
| cfg_ofs | input | 8 | Indirect offset selecting a bank word |
| cfg_wdata | input | 32 | Value to be masked and stored |
| cfg_rdata | output | 32 | Stored bank word at cfg_ofs, zero elsewhere |
| map_en | input | 1 | Controller-wide enable gating every bank |
| lookup_addr | input | 32 | Physical address to decode |
| bank_hit | output | 4 | One-hot bank hit |
| bank_miss | output | 1 | High when no bank holds the address |
| bank_offset | output | 32 | Address minus base of the winning bank |

## Verification
The bench probes the first and last byte of each window and the byte just past it; an off-by-one limit compare or a size shift from the wrong origin would hit one byte too many or lose the last byte. It writes all ones to check the store mask and sets bit 22 in a word to confirm that bits below 23 do not shift the base, and it places a window ending exactly at 4 GiB, where a 32-bit end computation wraps to zero and the top address misses. Overlapping windows show whether the priority favours the lowest bank, and reserved size codes, cleared enable bits and a low global enable must each leave the miss flag high.

// File: rtl/sdram_bank_dec_pkg.sv
package sdram_bank_dec_pkg;

   // Field positions inside a bank word; the window logic decodes these.
   localparam int unsigned BASE_LSB    = 23;
   localparam int unsigned CODE_LSB    = 17;
   localparam int unsigned CODE_W      = 3;
   localparam int unsigned EN_BIT      = 0;
   localparam int unsigned MIN_LOG2    = 22;   // 4 MiB at code zero

   localparam logic [31:0] STORE_MASK  = 32'hFFDE_E001;

   function automatic logic code_reserved(input logic [CODE_W-1:0] code);
      return &code;
   endfunction

endpackage

// File: rtl/bank_word_file.sv
module bank_word_file #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned OFS_W     = 8,
   parameter int unsigned FIRST_OFS = 'h40,
   parameter int unsigned STRIDE    = 4,
   parameter logic [DATA_W-1:0] MASK = '1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [OFS_W-1:0]     ofs,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   output logic [DATA_W-1:0]    words [NUM_BANKS]
);

   localparam int unsigned LAST_OFS = FIRST_OFS + STRIDE * (NUM_BANKS - 1);

   if (LAST_OFS >= (1 << OFS_W)) begin : g_bad_ofs
      $error("bank_word_file: offsets exceed OFS_W");
   end

   logic [NUM_BANKS-1:0] sel;

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_word
      assign sel[i] = (ofs == OFS_W'(FIRST_OFS + STRIDE * i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            words[i] <= '0;
         end else if (we && sel[i]) begin
            words[i] <= wdata & MASK;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (sel[i]) rdata = words[i];
      end
   end

endmodule

// File: rtl/bank_window_match.sv
module bank_window_match
   import sdram_bank_dec_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] word,
   input  logic              map_en,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [ADDR_W-1:0] offset
);

   localparam int unsigned MAX_LOG2 = MIN_LOG2 + (1 << CODE_W) - 2;

   if (MAX_LOG2 > ADDR_W) begin : g_bad_size
      $error("bank_window_match: largest window exceeds address space");
   end

   logic [ADDR_W-1:0] base;
   logic [CODE_W-1:0] code;
   logic [ADDR_W:0]   span;
   logic [ADDR_W:0]   limit;
   logic              above_base;
   logic              below_limit;

   assign base  = {word[ADDR_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
   assign code  = word[CODE_LSB +: CODE_W];
   // One extra bit keeps a window that ends at the top of the space from wrapping.
   assign span  = (ADDR_W+1)'(1) << (MIN_LOG2 + 32'(code));
   assign limit = {1'b0, base} + span;

   assign above_base  = (addr >= base);
   assign below_limit = ({1'b0, addr} < limit);

   assign hit    = map_en & word[EN_BIT] & ~code_reserved(code) & above_base & below_limit;
   assign offset = addr - base;

endmodule

// File: rtl/bank_priority_pick.sv
module bank_priority_pick #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned ADDR_W    = 32
) (
   input  logic [NUM_BANKS-1:0] hit_raw,
   input  logic [ADDR_W-1:0]    ofs_raw [NUM_BANKS],
   output logic [NUM_BANKS-1:0] hit_sel,
   output logic                 miss,
   output logic [ADDR_W-1:0]    ofs_sel
);

   always_comb begin
      hit_sel = '0;
      ofs_sel = '0;
      // Walk from the top down so the lowest index is the last to overwrite.
      for (int i = NUM_BANKS - 1; i >= 0; i--) begin
         if (hit_raw[i]) begin
            hit_sel    = '0;
            hit_sel[i] = 1'b1;
            ofs_sel    = ofs_raw[i];
         end
      end
   end

   assign miss = ~|hit_raw;

endmodule

// File: rtl/sdram_bank_decoder.sv
module sdram_bank_decoder
   import sdram_bank_dec_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned OFS_W     = 8,
   parameter int unsigned FIRST_OFS = 'h40,
   parameter int unsigned STRIDE    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [OFS_W-1:0]     cfg_ofs,
   input  logic [ADDR_W-1:0]    cfg_wdata,
   output logic [ADDR_W-1:0]    cfg_rdata,
   input  logic                 map_en,
   input  logic [ADDR_W-1:0]    lookup_addr,
   output logic [NUM_BANKS-1:0] bank_hit,
   output logic                 bank_miss,
   output logic [ADDR_W-1:0]    bank_offset
);

   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("sdram_bank_decoder: NUM_BANKS must be at least one");
   end
   if (ADDR_W != 32) begin : g_bad_width
      $error("sdram_bank_decoder: field layout assumes 32-bit words");
   end

   logic [ADDR_W-1:0]    words   [NUM_BANKS];
   logic [ADDR_W-1:0]    ofs_raw [NUM_BANKS];
   logic [NUM_BANKS-1:0] hit_raw;

   bank_word_file #(
      .NUM_BANKS (NUM_BANKS),
      .DATA_W    (ADDR_W),
      .OFS_W     (OFS_W),
      .FIRST_OFS (FIRST_OFS),
      .STRIDE    (STRIDE),
      .MASK      (STORE_MASK)
   ) u_words (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .ofs   (cfg_ofs),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .words (words)
   );

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_win
      bank_window_match #(
         .ADDR_W (ADDR_W)
      ) u_match (
         .word   (words[i]),
         .map_en (map_en),
         .addr   (lookup_addr),
         .hit    (hit_raw[i]),
         .offset (ofs_raw[i])
      );
   end

   bank_priority_pick #(
      .NUM_BANKS (NUM_BANKS),
      .ADDR_W    (ADDR_W)
   ) u_pick (
      .hit_raw (hit_raw),
      .ofs_raw (ofs_raw),
      .hit_sel (bank_hit),
      .miss    (bank_miss),
      .ofs_sel (bank_offset)
   );

endmodule

// File: rtl/sdram_bank_decoder_chk.sv
module sdram_bank_decoder_chk #(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned ADDR_W    = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 map_en,
   input logic [ADDR_W-1:0]    cfg_rdata,
   input logic [NUM_BANKS-1:0] bank_hit,
   input logic                 bank_miss,
   input logic [ADDR_W-1:0]    bank_offset
);

   p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_hit));

   p_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bank_miss == (bank_hit == '0));

   p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !map_en |-> (bank_miss && bank_hit == '0));

   p_offset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bank_miss |-> (bank_offset == '0));

   p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & ~sdram_bank_dec_pkg::STORE_MASK) == '0);

endmodule

bind sdram_bank_decoder sdram_bank_decoder_chk #(
   .NUM_BANKS (NUM_BANKS),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .map_en      (map_en),
   .cfg_rdata   (cfg_rdata),
   .bank_hit    (bank_hit),
   .bank_miss   (bank_miss),
   .bank_offset (bank_offset)
);

// File: tb/sdram_bank_decoder_tb.sv
module sdram_bank_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_ofs = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        map_en = 1'b0;
   logic [31:0] lookup_addr = '0;
   logic [3:0]  bank_hit;
   logic        bank_miss;
   logic [31:0] bank_offset;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #4 clk = ~clk;   // 125 MHz

   sdram_bank_decoder u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_ofs     (cfg_ofs),
      .cfg_wdata   (cfg_wdata),
      .cfg_rdata   (cfg_rdata),
      .map_en      (map_en),
      .lookup_addr (lookup_addr),
      .bank_hit    (bank_hit),
      .bank_miss   (bank_miss),
      .bank_offset (bank_offset)
   );

   function automatic logic [31:0] mk(input logic [31:0] base, input int code, input bit en);
      return (base & 32'hFF80_0000) | (32'(code) << 17) | 32'(en);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] ofs, input logic [31:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ofs = ofs; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [7:0] ofs, input logic [31:0] exp);
      cfg_ofs = ofs;
      #1;
      check(req, cfg_rdata, exp);
   endtask

   task automatic look(input string req, input logic [31:0] a,
                       input logic [3:0] exp_hit, input logic [31:0] exp_ofs);
      lookup_addr = a;
      #1;
      check({req, " hit"}, 32'(bank_hit), 32'(exp_hit));
      check({req, " miss"}, 32'(bank_miss), 32'(exp_hit == 4'b0));
      check({req, " offset"}, bank_offset, exp_ofs);
   endtask

   task automatic t_reset;
      for (int i = 0; i < 4; i++) rd_check("R1 word", 8'(8'h40 + 4*i), 32'h0);
      map_en = 1'b1;
      look("R1", 32'h0, 4'b0, 32'h0);
   endtask

   task automatic t_mask;
      wr(8'h44, 32'hFFFF_FFFF);
      rd_check("R2 mask", 8'h44, 32'hFFDE_E001);
      wr(8'h44, 32'h0);
      rd_check("R2 clear", 8'h44, 32'h0);
   endtask

   task automatic t_ignore;
      wr(8'h42, 32'hFFFF_FFFF);
      wr(8'h50, 32'hFFFF_FFFF);
      wr(8'h3C, 32'hFFFF_FFFF);
      for (int i = 0; i < 4; i++) rd_check("R3 untouched", 8'(8'h40 + 4*i), 32'h0);
      rd_check("R3 unmapped read", 8'h42, 32'h0);
      look("R3", 32'h0, 4'b0, 32'h0);
   endtask

   task automatic t_basic;
      wr(8'h40, mk(32'h0000_0000, 2, 1));   // 16 MiB
      wr(8'h44, mk(32'h1000_0000, 0, 1));   // 4 MiB
      look("R4 b0 first", 32'h0000_0000, 4'b0001, 32'h0);
      look("R4 b0 last",  32'h00FF_FFFF, 4'b0001, 32'h00FF_FFFF);
      look("R4 b0 past",  32'h0100_0000, 4'b0, 32'h0);
      look("R4 b1 below", 32'h0FFF_FFFF, 4'b0, 32'h0);
      look("R4 b1 last",  32'h103F_FFFF, 4'b0010, 32'h003F_FFFF);
      look("R4 b1 past",  32'h1040_0000, 4'b0, 32'h0);
   endtask

   task automatic t_reserved;
      wr(8'h48, mk(32'h2000_0000, 7, 1));
      look("R5 code7", 32'h2000_0000, 4'b0, 32'h0);
      look("R5 code7 hi", 32'h2100_0000, 4'b0, 32'h0);
   endtask

   task automatic t_bank_en;
      wr(8'h4C, mk(32'h3000_0000, 1, 0));
      look("R6 off", 32'h3000_0010, 4'b0, 32'h0);
      wr(8'h4C, mk(32'h3000_0000, 1, 1) | 32'h0040_0000);   // bit 22 set, base unchanged
      rd_check("R2 bit22 kept", 8'h4C, 32'h3042_0001);
      look("R6 on R4 base", 32'h3000_0010, 4'b1000, 32'h10);
      look("R4 8MiB last", 32'h307F_FFFF, 4'b1000, 32'h007F_FFFF);
   endtask

   task automatic t_global;
      map_en = 1'b0;
      #1;
      look("R7 off b0", 32'h0000_0100, 4'b0, 32'h0);
      look("R7 off b3", 32'h3000_0000, 4'b0, 32'h0);
      map_en = 1'b1;
      look("R7 back", 32'h0000_0100, 4'b0001, 32'h100);
   endtask

   task automatic t_overlap;
      wr(8'h44, mk(32'h0000_0000, 3, 1));   // 32 MiB over bank 0
      look("R8 low wins", 32'h0010_0000, 4'b0001, 32'h0010_0000);
      look("R8 b1 only", 32'h0180_0000, 4'b0010, 32'h0180_0000);
      wr(8'h40, mk(32'h0000_0000, 2, 0));
      look("R8 b0 off", 32'h0010_0000, 4'b0010, 32'h0010_0000);
   endtask

   task automatic t_top;
      wr(8'h48, mk(32'hF000_0000, 6, 1));   // 256 MiB ending at 4 GiB
      look("R11 top", 32'hFFFF_FFFF, 4'b0100, 32'h0FFF_FFFF);
      look("R11 base", 32'hF000_0000, 4'b0100, 32'h0);
      look("R9 R11 below", 32'hEFFF_FFFF, 4'b0, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_mask;
      t_ignore;
      t_basic;
      t_reserved;
      t_bank_en;
      t_global;
      t_overlap;
      t_top;
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule